// File: doc/BRIEF.md
# Four-Function Operand Unit

A purely combinational datapath slice that takes two unsigned operands of equal width and a two-bit function code, and returns one result of the operand width. The four functions are a bitwise exclusive-OR, a logical left shift of the first operand by the second, the remainder of the first operand divided by the second, and the bitwise inverse of the operands' AND.

The unit holds no state and has no clock. A change on any input reaches the result within the same evaluation. Two edge cases are fixed by definition. A shift distance at or above the operand width returns zero. A zero divisor makes the remainder function return zero.

Top module: `quad_op_unit`

## Requirements
- R1: With function code 0 the result equals `a_i ^ b_i` for every operand pair.
- R2: With function code 1 the result is `a_i` shifted left by `b_i` bit positions. Vacated low bits are zero, and any `b_i` of WIDTH (8) or more gives zero.
- R3: With function code 2 the result is the remainder of `a_i` divided by `b_i`. When `b_i` is zero the result is zero.
- R4: With function code 3 the result equals `~(a_i & b_i)` for every operand pair.
- R5: For function code 1, bits shifted beyond the most significant position are discarded, so the result never exceeds WIDTH bits.
- R6: For function code 2 with a nonzero divisor, the result is always below `b_i`. When `a_i` is below `b_i`, the result equals `a_i`.
- R7: The result depends only on the present inputs. No clock edge is needed for it to change, and all-zero inputs with function code 0 give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand; also the shift distance and the divisor |
| op_i | input | 2 | Function code: 0 xor, 1 shift left, 2 remainder, 3 inverted and |
| res_o | output | WIDTH | Selected result |

## Verification
Random stimulus rarely reaches the remainder unit's last subtract stage with the largest dividends and divisors close to them. A zero divisor also lies outside normal division. Shift distances past the width only show whether the high bits of the distance are decoded. The bench reaches all of these by sweeping all 65,536 operand pairs under each of the four function codes. It compares every result with an arithmetic reference. Each check is also labelled with the edge-case requirement it covers.

// File: rtl/quad_op_pkg.sv
package quad_op_pkg;

  typedef enum logic [1:0] {
    FN_XOR   = 2'd0,
    FN_SHL   = 2'd1,
    FN_REM   = 2'd2,
    FN_NAND  = 2'd3
  } fn_code_e;

endpackage

// File: rtl/qo_logic_unit.sv
module qo_logic_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nand_o
);

  always_comb begin
    xor_o  = a_i ^ b_i;
    nand_o = ~(a_i & b_i);
    // R1: xor result recovers b when combined with a again
    a_r1_xor_inverse : assert ((xor_o ^ a_i) == b_i);
    // R4: no result bit may be set where both operands are set, and every other bit is set
    a_r4_nand_cover : assert (((nand_o & a_i & b_i) == '0) && ((nand_o | (a_i & b_i)) == '1));
  end

endmodule

// File: rtl/qo_shifter.sv
module qo_shifter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] dist_i,
  output logic [WIDTH-1:0] shl_o
);

  localparam int STAGES = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] stage [STAGES+1];
  logic             over_range;

  assign stage[0] = val_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign stage[s+1] = dist_i[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  if (STAGES < WIDTH) begin : g_hi
    assign over_range = |dist_i[WIDTH-1:STAGES];
  end else begin : g_nohi
    assign over_range = 1'b0;
  end

  always_comb begin
    shl_o = over_range ? '0 : stage[STAGES];
    // R2: the low dist bits of a shifted value must be zero
    if (dist_i < WIDTH) begin
      a_r2_low_clear : assert ((shl_o & ((WIDTH'(1) << dist_i) - WIDTH'(1))) == '0);
    end else begin
      a_r2_big_shift_zero : assert (shl_o == '0);
    end
  end

endmodule

// File: rtl/qo_remainder.sv
module qo_remainder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] rem_o
);

  logic [WIDTH:0] partial;
  logic [WIDTH:0] divisor_ext;

  always_comb begin
    divisor_ext = {1'b0, divisor_i};
    partial     = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      partial = {partial[WIDTH-1:0], dividend_i[i]};
      if (partial >= divisor_ext) begin
        partial = partial - divisor_ext;
      end
    end
    rem_o = (divisor_i == '0) ? '0 : partial[WIDTH-1:0];
    if (divisor_i != '0) begin
      // R6: remainder stays strictly below the divisor
      a_r6_rem_bound : assert (rem_o < divisor_i);
      // R3: remainder never exceeds the dividend
      a_r3_rem_le_dividend : assert (rem_o <= dividend_i);
    end
  end

endmodule

// File: rtl/quad_op_unit.sv
module quad_op_unit
  import quad_op_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o
);

  logic [WIDTH-1:0] xor_res;
  logic [WIDTH-1:0] nand_res;
  logic [WIDTH-1:0] shl_res;
  logic [WIDTH-1:0] rem_res;
  fn_code_e         fn;

  qo_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i    (a_i),
    .b_i    (b_i),
    .xor_o  (xor_res),
    .nand_o (nand_res)
  );

  qo_shifter #(.WIDTH(WIDTH)) u_shift (
    .val_i  (a_i),
    .dist_i (b_i),
    .shl_o  (shl_res)
  );

  qo_remainder #(.WIDTH(WIDTH)) u_rem (
    .dividend_i (a_i),
    .divisor_i  (b_i),
    .rem_o      (rem_res)
  );

  always_comb begin
    fn = fn_code_e'(op_i);
    unique case (fn)
      FN_XOR:  res_o = xor_res;
      FN_SHL:  res_o = shl_res;
      FN_REM:  res_o = rem_res;
      default: res_o = nand_res;
    endcase
    // R3: zero divisor on the remainder path yields zero at the port
    if (fn == FN_REM && b_i == '0) begin
      a_r3_zero_divisor : assert (res_o == '0);
    end
    // R7: all-zero inputs under the xor code give zero
    if (fn == FN_XOR && a_i == '0 && b_i == '0) begin
      a_r7_zero_in_zero_out : assert (res_o == '0);
    end
  end

endmodule

// File: tb/quad_op_unit_test.sv
module quad_op_unit_test;

  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 100000;

  logic         clk;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [1:0]   op;
  logic [W-1:0] res;

  int n_checks;
  int n_fails;
  bit finished;

  quad_op_unit #(.WIDTH(W)) uut (
    .a_i   (a),
    .b_i   (b),
    .op_i  (op),
    .res_o (res)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", tag, op, a, b, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input int o, input int x, input int y);
    int r;
    case (o)
      0: r = x ^ y;
      1: r = (y >= W) ? 0 : ((x * (1 << y)) % (1 << W));
      2: r = (y == 0) ? 0 : (x % y);
      default: r = ((1 << W) - 1) - (x & y);
    endcase
    return r[W-1:0];
  endfunction

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    // R7: zero inputs under code 0 give zero, with no clock edge involved
    a = '0; b = '0; op = 2'd0;
    #1;
    check("R7", res, '0);
    // R7: a change is visible after a delay shorter than any clock phase
    a = 8'h5A; b = 8'h0F;
    #1;
    check("R7", res, 8'h55);
    #3;
    for (int o = 0; o < 4; o++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          op = o[1:0]; a = x[W-1:0]; b = y[W-1:0];
          #1;
          case (o)
            0: check("R1", res, model(o, x, y));
            1: begin
              if (y >= W) check("R2", res, '0);
              else if ((x << y) >= (1 << W)) check("R5", res, model(o, x, y));
              else check("R2", res, model(o, x, y));
            end
            2: begin
              if (y == 0) check("R3", res, '0);
              else if (x < y) check("R6", res, x[W-1:0]);
              else check("R3", res, model(o, x, y));
            end
            default: check("R4", res, model(o, x, y));
          endcase
        end
      end
    end
    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule